// File: doc/BRIEF.md
# Stack Processor Branch Control Unit

This unit decides where a byte-oriented stack processor fetches its next instruction after a control-flow opcode. Each cycle that `in_valid` is high it takes the address of the current instruction, its opcode byte, the following two operand bytes, the top data-stack byte and the carry flag. One clock later it presents the next instruction address, whether the top data-stack byte must be dropped or decremented, how many processor cycles the instruction costs, and an illegal-opcode flag.

The unit owns a small return stack that grows toward lower addresses. A relative call stores its 16-bit return address as two bytes, high byte at the lower address, and reports that write on a write port. A return rebuilds the address from the same two bytes and releases them. Instruction fetch, the data stack and all arithmetic other than address arithmetic belong to neighbouring blocks.

The short-branch opcodes carry their jump distance in the low nibble, so a whole group of sixteen opcodes maps onto one branch form. All instruction addresses are 16 bits and wrap modulo 65536.

Top module: `stk_branch_ctl`

## Requirements
- R1: Opcodes 0x20 to 0x2F jump unconditionally to IP + (low nibble + 1), cost 1 cycle and request no drop and no decrement.
- R2: Opcodes 0x40 to 0x4F branch to IP + (low nibble + 1) when TOS is zero, and opcodes 0x60 to 0x6F do so when TOS is non-zero; otherwise the next IP is IP + 1. Both groups always request a TOS drop and cost 3 cycles.
- R3: Opcode 0x73 is two bytes long. When TOS is zero the next IP is IP + 2 + the sign-extended first operand, otherwise IP + 2. It always requests a TOS drop and costs 4 cycles.
- R4: Opcode 0x70 branches to IP + 2 + the sign-extended first operand when the carry is set, and opcode 0x71 does so when the carry is clear; otherwise the next IP is IP + 2. Neither touches TOS, and each costs 4 cycles.
- R5: Opcode 0x75 is three bytes long and always jumps to IP + 3 + a signed 16-bit displacement. The first operand is the high byte of that displacement. It costs 4 cycles.
- R6: Opcode 0x72 always requests a TOS decrement. It branches to IP + 2 + the sign-extended first operand when TOS − 1 (8-bit, wrapping) is non-zero. Otherwise it goes to IP + 2 and also requests a TOS drop. It costs 5 cycles.
- R7: Opcode 0x74 jumps to IP + 2 + the sign-extended first operand, which gives a reach of −126 to +129. It writes the return address IP + 2 with its high byte at return-stack pointer − 2 and its low byte at pointer − 1, reporting the high-byte address and the 16-bit word on the write port. The pointer then drops by 2. It costs 5 cycles.
- R8: Opcode 0x7F takes its next IP from the byte at the pointer (high) and the byte at pointer + 1 (low), raises the pointer by 2 and costs 4 cycles. Nested calls return in last-in, first-out order.
- R9: Any other opcode gives a next IP of IP + 1, raises the illegal flag, costs 1 cycle and leaves the return stack alone.
- R10: All results appear on the clock edge after an accepted instruction, with `out_valid` high for that one cycle. A cycle without `in_valid` produces no result and leaves the pointer unchanged.
- R11: After reset, `out_valid` and every request output are low and the return-stack pointer is 0.
- R12: Every address computation wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| ip_in | input | 16 | Address of the presented instruction |
| opcode | input | 8 | Opcode byte |
| opnd_a | input | 8 | First operand byte |
| opnd_b | input | 8 | Second operand byte |
| tos | input | 8 | Top data-stack byte |
| carry_in | input | 1 | Carry flag |
| out_valid | output | 1 | Results below are valid |
| next_ip | output | 16 | Address of the next instruction |
| drop_tos | output | 1 | Drop the top data-stack byte |
| dec_tos | output | 1 | Decrement the top data-stack byte |
| illegal_op | output | 1 | Opcode is not a control-flow opcode |
| cycles | output | 3 | Processor cycles the instruction costs |
| rs_we | output | 1 | Return-stack word written this result |
| rs_waddr | output | RS_AW | Address of the high byte written |
| rs_wdata | output | 16 | Return address written |
| rs_ptr | output | RS_AW | Current return-stack pointer |

## Verification
The bench targets the edges of the nibble distance (0x20 and 0x2F), where an off-by-one in the distance lands every short branch one byte short or long. It runs the decrement branch with TOS at 1 and at 0. A unit that tests TOS itself rather than TOS − 1 inverts both outcomes, and one that skips the wrap stalls the loop counter. Negative displacements and a branch across 0xFFFF expose missing sign extension or wrap. Two nested calls followed by two returns expose a swapped byte order or a pointer moved the wrong way, because the returns then land on the wrong addresses.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int IP_W = 16;

    localparam logic [7:0] OP_BRC   = 8'h70;
    localparam logic [7:0] OP_BRNC  = 8'h71;
    localparam logic [7:0] OP_DBRNZ = 8'h72;
    localparam logic [7:0] OP_BRZ   = 8'h73;
    localparam logic [7:0] OP_CALLR = 8'h74;
    localparam logic [7:0] OP_BRF   = 8'h75;
    localparam logic [7:0] OP_RET   = 8'h7F;

    typedef enum logic [3:0] {
        K_SHORT, K_SHORT_Z, K_SHORT_NZ, K_REL_Z, K_REL_C, K_REL_NC,
        K_FAR, K_DEC_NZ, K_CALL, K_RETURN, K_BAD
    } kind_e;

    function automatic kind_e classify(input logic [7:0] op);
        kind_e k;
        case (op[7:4])
            4'h2: k = K_SHORT;
            4'h4: k = K_SHORT_Z;
            4'h6: k = K_SHORT_NZ;
            4'h7: begin
                case (op)
                    OP_BRC:   k = K_REL_C;
                    OP_BRNC:  k = K_REL_NC;
                    OP_DBRNZ: k = K_DEC_NZ;
                    OP_BRZ:   k = K_REL_Z;
                    OP_CALLR: k = K_CALL;
                    OP_BRF:   k = K_FAR;
                    OP_RET:   k = K_RETURN;
                    default:  k = K_BAD;
                endcase
            end
            default: k = K_BAD;
        endcase
        return k;
    endfunction

    function automatic logic [2:0] cost(input kind_e k);
        case (k)
            K_SHORT_Z, K_SHORT_NZ:                   return 3'd3;
            K_REL_Z, K_REL_C, K_REL_NC, K_FAR, K_RETURN: return 3'd4;
            K_DEC_NZ, K_CALL:                        return 3'd5;
            default:                                 return 3'd1;
        endcase
    endfunction

    function automatic logic [1:0] length(input kind_e k);
        case (k)
            K_REL_Z, K_REL_C, K_REL_NC, K_DEC_NZ, K_CALL: return 2'd2;
            K_FAR:                                        return 2'd3;
            default:                                      return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] tos,
    input  logic       carry_in,
    output kind_e      kind,
    output logic       taken,
    output logic       drop,
    output logic       dec
);
    logic tos_zero;
    logic dec_zero;

    assign tos_zero = (tos == 8'd0);
    assign dec_zero = ((tos - 8'd1) == 8'd0);

    always_comb begin
        kind  = classify(opcode);
        taken = 1'b0;
        drop  = 1'b0;
        dec   = 1'b0;
        case (kind)
            K_SHORT:    taken = 1'b1;
            K_SHORT_Z:  begin taken = tos_zero;  drop = 1'b1; end
            K_SHORT_NZ: begin taken = !tos_zero; drop = 1'b1; end
            K_REL_Z:    begin taken = tos_zero;  drop = 1'b1; end
            K_REL_C:    taken = carry_in;
            K_REL_NC:   taken = !carry_in;
            K_FAR:      taken = 1'b1;
            K_DEC_NZ:   begin taken = !dec_zero; dec = 1'b1; drop = dec_zero; end
            K_CALL:     taken = 1'b1;
            K_RETURN:   taken = 1'b1;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcu_target.sv
module bcu_target
    import bcu_pkg::*;
(
    input  logic [IP_W-1:0] ip,
    input  kind_e           kind,
    input  logic            taken,
    input  logic [3:0]      nib,
    input  logic [7:0]      opnd_a,
    input  logic [7:0]      opnd_b,
    input  logic [IP_W-1:0] ret_word,
    output logic [IP_W-1:0] seq_ip,
    output logic [IP_W-1:0] target
);
    logic [IP_W-1:0] short_dst;
    logic [IP_W-1:0] rel8_dst;
    logic [IP_W-1:0] far_dst;

    assign seq_ip    = ip + IP_W'(length(kind));
    assign short_dst = ip + IP_W'(nib) + IP_W'(1);
    assign rel8_dst  = ip + IP_W'(2) + {{(IP_W-8){opnd_a[7]}}, opnd_a};
    assign far_dst   = ip + IP_W'(3) + {opnd_a, opnd_b};

    always_comb begin
        target = seq_ip;
        if (taken) begin
            case (kind)
                K_SHORT, K_SHORT_Z, K_SHORT_NZ:            target = short_dst;
                K_REL_Z, K_REL_C, K_REL_NC, K_DEC_NZ, K_CALL: target = rel8_dst;
                K_FAR:                                     target = far_dst;
                K_RETURN:                                  target = ret_word;
                default:                                   target = seq_ip;
            endcase
        end
    end
endmodule

// File: rtl/bcu_rstack.sv
module bcu_rstack
    import bcu_pkg::*;
#(
    parameter int RS_AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [IP_W-1:0]  push_word,
    output logic [RS_AW-1:0] ptr,
    output logic [RS_AW-1:0] wr_base,
    output logic [IP_W-1:0]  top_word
);
    localparam int DEPTH = 1 << RS_AW;
    localparam int BYTES = IP_W / 8;

    logic [7:0] mem [DEPTH];

    assign wr_base = ptr - RS_AW'(BYTES);

    always_comb begin
        top_word = '0;
        for (int b = 0; b < BYTES; b++)
            top_word[IP_W-1-8*b -: 8] = mem[ptr + RS_AW'(b)];
    end

    always_ff @(posedge clk) begin
        if (push) begin
            for (int b = 0; b < BYTES; b++)
                mem[wr_base + RS_AW'(b)] <= push_word[IP_W-1-8*b -: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (push) ptr <= wr_base;
        else if (pop)  ptr <= ptr + RS_AW'(BYTES);
    end

    a_r7_push_lowers_ptr: assert property (@(posedge clk) disable iff (rst)
        push |=> ptr == $past(ptr) - RS_AW'(BYTES));
    a_r8_pop_raises_ptr: assert property (@(posedge clk) disable iff (rst)
        pop |=> ptr == $past(ptr) + RS_AW'(BYTES));
    a_r10_idle_holds_ptr: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(ptr));
    always_comb a_r8_single_op: assert (!(push && pop));
endmodule

// File: rtl/stk_branch_ctl.sv
module stk_branch_ctl
    import bcu_pkg::*;
#(
    parameter int RS_AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [15:0]      ip_in,
    input  logic [7:0]       opcode,
    input  logic [7:0]       opnd_a,
    input  logic [7:0]       opnd_b,
    input  logic [7:0]       tos,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [15:0]      next_ip,
    output logic             drop_tos,
    output logic             dec_tos,
    output logic             illegal_op,
    output logic [2:0]       cycles,
    output logic             rs_we,
    output logic [RS_AW-1:0] rs_waddr,
    output logic [15:0]      rs_wdata,
    output logic [RS_AW-1:0] rs_ptr
);
    kind_e            kind;
    logic             taken, drop, dec;
    logic [IP_W-1:0]  seq_ip, target, ret_word;
    logic [RS_AW-1:0] wr_base;
    logic             do_push, do_pop;

    bcu_decode u_dec (
        .opcode(opcode), .tos(tos), .carry_in(carry_in),
        .kind(kind), .taken(taken), .drop(drop), .dec(dec)
    );

    bcu_target u_tgt (
        .ip(ip_in), .kind(kind), .taken(taken), .nib(opcode[3:0]),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .ret_word(ret_word),
        .seq_ip(seq_ip), .target(target)
    );

    assign do_push = in_valid && (kind == K_CALL);
    assign do_pop  = in_valid && (kind == K_RETURN);

    bcu_rstack #(.RS_AW(RS_AW)) u_rs (
        .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
        .push_word(seq_ip), .ptr(rs_ptr), .wr_base(wr_base),
        .top_word(ret_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            next_ip    <= '0;
            drop_tos   <= 1'b0;
            dec_tos    <= 1'b0;
            illegal_op <= 1'b0;
            cycles     <= '0;
            rs_we      <= 1'b0;
            rs_waddr   <= '0;
            rs_wdata   <= '0;
        end else begin
            out_valid  <= in_valid;
            next_ip    <= in_valid ? target : next_ip;
            drop_tos   <= in_valid && drop;
            dec_tos    <= in_valid && dec;
            illegal_op <= in_valid && (kind == K_BAD);
            cycles     <= in_valid ? cost(kind) : 3'd0;
            rs_we      <= do_push;
            rs_waddr   <= do_push ? wr_base : '0;
            rs_wdata   <= do_push ? seq_ip : '0;
        end
    end

    a_r9_illegal_steps_one: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal_op) |-> (next_ip == $past(ip_in) + 16'd1 && !rs_we && cycles == 3'd1));
    a_r10_result_follows_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !rs_we && !drop_tos && !dec_tos));
    a_r2_short_cond_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode[7:4] == 4'h4 || opcode[7:4] == 4'h6)) |=> (drop_tos && cycles == 3'd3));
    a_r6_dec_only_loop: assert property (@(posedge clk) disable iff (rst)
        dec_tos |-> (cycles == 3'd5 && !rs_we));
    a_r7_write_below_ptr: assert property (@(posedge clk) disable iff (rst)
        rs_we |-> (rs_waddr == rs_ptr && rs_wdata == $past(ip_in) + 16'd2));
    a_r1_short_no_stack_effect: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[7:4] == 4'h2) |=> (!drop_tos && !dec_tos && cycles == 3'd1));
endmodule

// File: tb/test_stk_branch_ctl.sv
module test_stk_branch_ctl;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [15:0] ip_in = '0;
    logic [7:0] opcode = '0, opnd_a = '0, opnd_b = '0, tos = '0;
    logic carry_in = 1'b0;
    logic out_valid, drop_tos, dec_tos, illegal_op, rs_we;
    logic [15:0] next_ip, rs_wdata;
    logic [2:0] cycles;
    logic [AW-1:0] rs_waddr, rs_ptr;

    int checks = 0;
    int errors = 0;
    logic [7:0] rmem [32];
    int mptr = 0;

    always #10ns clk = ~clk;

    stk_branch_ctl #(.RS_AW(AW)) i_stk_branch_ctl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ip_in(ip_in), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .tos(tos), .carry_in(carry_in),
        .out_valid(out_valid), .next_ip(next_ip), .drop_tos(drop_tos), .dec_tos(dec_tos),
        .illegal_op(illegal_op), .cycles(cycles), .rs_we(rs_we), .rs_waddr(rs_waddr),
        .rs_wdata(rs_wdata), .rs_ptr(rs_ptr)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(string tag, logic [15:0] ip, logic [7:0] op,
                         logic [7:0] a, logic [7:0] b, logic [7:0] t, logic c);
        logic [15:0] e_ip, rel8, ret;
        logic e_drop, e_dec, e_ill, e_we;
        logic [2:0] e_cyc;
        logic [AW-1:0] e_wa;
        logic [15:0] e_wd;
        logic [7:0] tm1;
        e_ip = ip + 16'd1; e_drop = 0; e_dec = 0; e_ill = 0; e_we = 0;
        e_cyc = 3'd1; e_wa = '0; e_wd = '0;
        rel8 = ip + 16'd2 + {{8{a[7]}}, a};
        tm1 = t - 8'd1;
        case (op[7:4])
            4'h2: e_ip = ip + 16'(op[3:0]) + 16'd1;
            4'h4: begin e_drop = 1; e_cyc = 3; if (t == 0) e_ip = ip + 16'(op[3:0]) + 16'd1; end
            4'h6: begin e_drop = 1; e_cyc = 3; if (t != 0) e_ip = ip + 16'(op[3:0]) + 16'd1; end
            4'h7: begin
                case (op)
                    8'h70: begin e_cyc = 4; e_ip = c ? rel8 : ip + 16'd2; end
                    8'h71: begin e_cyc = 4; e_ip = !c ? rel8 : ip + 16'd2; end
                    8'h72: begin e_cyc = 5; e_dec = 1; e_drop = (tm1 == 0);
                                 e_ip = (tm1 != 0) ? rel8 : ip + 16'd2; end
                    8'h73: begin e_cyc = 4; e_drop = 1; e_ip = (t == 0) ? rel8 : ip + 16'd2; end
                    8'h74: begin
                        e_cyc = 5; e_ip = rel8; e_we = 1;
                        ret = ip + 16'd2;
                        mptr = (mptr + 30) % 32;
                        rmem[mptr] = ret[15:8];
                        rmem[(mptr + 1) % 32] = ret[7:0];
                        e_wa = AW'(mptr); e_wd = ret;
                    end
                    8'h75: begin e_cyc = 4; e_ip = ip + 16'd3 + {a, b}; end
                    8'h7F: begin
                        e_cyc = 4; e_ip = {rmem[mptr], rmem[(mptr + 1) % 32]};
                        mptr = (mptr + 2) % 32;
                    end
                    default: e_ill = 1;
                endcase
            end
            default: e_ill = 1;
        endcase
        @(negedge clk);
        in_valid = 1; ip_in = ip; opcode = op; opnd_a = a; opnd_b = b; tos = t; carry_in = c;
        @(negedge clk);
        in_valid = 0;
        check(tag, 64'({out_valid, next_ip, drop_tos, dec_tos, illegal_op, cycles,
                        rs_we, rs_waddr, rs_wdata, rs_ptr}),
                   64'({1'b1, e_ip, e_drop, e_dec, e_ill, e_cyc,
                        e_we, e_wa, e_wd, AW'(mptr)}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rmem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        check("R11 reset", 64'({out_valid, drop_tos, dec_tos, illegal_op, rs_we, rs_ptr}), 64'(0));
        // R1 short unconditional
        issue("R1 sbr 0x29", 16'h1000, 8'h29, 0, 0, 8'h05, 0);
        issue("R1 sbr 0x20", 16'h2000, 8'h20, 0, 0, 8'h00, 0);
        issue("R1 sbr 0x2F", 16'h2000, 8'h2F, 0, 0, 8'h00, 0);
        // R2 short conditional
        issue("R2 sbrz taken", 16'h0300, 8'h43, 0, 0, 8'h00, 0);
        issue("R2 sbrz not", 16'h0300, 8'h43, 0, 0, 8'h05, 0);
        issue("R2 sbrnz taken", 16'h0300, 8'h6A, 0, 0, 8'h80, 0);
        issue("R2 sbrnz not", 16'h0300, 8'h6A, 0, 0, 8'h00, 0);
        // R3 branch on zero
        issue("R3 brz back", 16'h0400, 8'h73, 8'hF0, 0, 8'h00, 0);
        issue("R3 brz fall", 16'h0400, 8'h73, 8'hF0, 0, 8'h01, 0);
        // R4 carry branches
        issue("R4 brc set", 16'h0500, 8'h70, 8'h10, 0, 8'h00, 1);
        issue("R4 brc clr", 16'h0500, 8'h70, 8'h10, 0, 8'h00, 0);
        issue("R4 brnc clr", 16'h0500, 8'h71, 8'h80, 0, 8'h00, 0);
        issue("R4 brnc set", 16'h0500, 8'h71, 8'h80, 0, 8'h00, 1);
        // R5 far branch
        issue("R5 far fwd", 16'h0600, 8'h75, 8'h12, 8'h34, 8'h00, 0);
        issue("R5 far back", 16'h0600, 8'h75, 8'hFF, 8'h00, 8'h00, 0);
        // R6 decrement loop
        issue("R6 dbrnz 7", 16'h0700, 8'h72, 8'hFC, 0, 8'h07, 0);
        issue("R6 dbrnz 1", 16'h0700, 8'h72, 8'hFC, 0, 8'h01, 0);
        issue("R6 dbrnz 0", 16'h0700, 8'h72, 8'hFC, 0, 8'h00, 0);
        // R7 / R8 nested calls then returns
        issue("R7 callr max", 16'h1234, 8'h74, 8'h7F, 0, 8'h00, 0);
        issue("R7 callr min", 16'h12B5, 8'h74, 8'h80, 0, 8'h00, 0);
        issue("R8 ret inner", 16'h1237, 8'h7F, 0, 0, 8'h00, 0);
        issue("R8 ret outer", 16'h12B7, 8'h7F, 0, 0, 8'h00, 0);
        // R9 illegal opcodes
        issue("R9 illegal 00", 16'h0800, 8'h00, 0, 0, 8'h00, 0);
        issue("R9 illegal 7E", 16'h0800, 8'h7E, 0, 0, 8'h00, 0);
        issue("R9 illegal FF", 16'hFFFF, 8'hFF, 0, 0, 8'h00, 0);
        // R12 wrap
        issue("R12 sbr wrap", 16'hFFFE, 8'h23, 0, 0, 8'h00, 0);
        issue("R12 call wrap", 16'hFFFF, 8'h74, 8'h01, 0, 8'h00, 0);
        issue("R12 ret wrap", 16'h0004, 8'h7F, 0, 0, 8'h00, 0);
        // R10 idle cycle produces nothing
        @(negedge clk);
        check("R10 idle", 64'({out_valid, rs_we, drop_tos, dec_tos, rs_ptr}), 64'({4'b0, AW'(mptr)}));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule